// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller gathers interrupt requests from a parameterised, linearly numbered set of peripheral sources. Each request is captured in a per-source pending flag and then qualified by a per-source enable bit. Among the qualified sources, the controller chooses the one with the highest priority code. It presents that source's vector number, its priority code and a programmable 32-bit vector offset to the processor, and raises a request line while any qualified source exists.

Sources come in two kinds. A persistent (level) source keeps its flag set for as long as its request is high, and a clear of that flag only takes effect once the request has dropped. A non-persistent (edge) source sets its flag on a request edge, and the flag stays set until software clears it. A contiguous window of sources serves as external inputs, and each of these has a software-selected edge polarity. All storage sits behind a simple word-addressed register bus: address, write data and write strobe go in, and combinational read data comes out. Every bank word has a plain write address, a clear alias and a set alias.

Top module: `vec_intc`

## Requirements
- R1: After reset, every register reads zero, and irq_req, irq_vec, irq_prio and irq_vec_off are zero.
- R2: Bank words lie 0x10 apart. Flag words start at 0x040 and enable words start at 0x0C0. Source n is bit n%32 of word n/32. Address word+0x0 loads the written value. Word+0x4 clears the bits written as 1. Word+0x8 sets the bits written as 1. All other bits stay unchanged.
- R3: The priority code of source n is 5 bits wide: major in [4:2], sub in [1:0]. It sits in the word at 0x140+0x10*(n/4), at bit (n%4)*8. The upper 3 bits of each 8-bit lane read zero. The same +0x4 clear and +0x8 set aliases apply.
- R4: An edge source sets its flag on a rising request edge. The flag then holds after the request drops, and it stays clear after a software clear while the request is still high.
- R5: A level source (LEVEL_MAP bit set; by default sources 4 to 7) has its flag set while its request is high. Any clear of that flag has no effect while the request is high. Once the request is low, the flag holds until it is cleared.
- R6: Sources EXT_BASE..EXT_BASE+NUM_EXT-1 (by default 8 to 15) are edge sources with selectable polarity. Bit k of the control word at 0x000 (aliases +0x4 and +0x8) selects the rising edge when 1 and the falling edge when 0 for source EXT_BASE+k.
- R7: A source is a candidate when its flag is set, it is enabled and its major priority is not zero. The highest 5-bit code wins, and a tie goes to the lowest source number. irq_req is 1 exactly when a candidate exists.
- R8: The status word at 0x020 reads {prio[12:8], vector[7:0]} of the winner, or zero when there is none. Writes to it are ignored.
- R9: Vector v has a 32-bit offset register at 0x540+4*v. irq_vec_off carries the winner's offset, or zero when there is none.
- R10: A source whose major priority is 0 never raises irq_req, even when it is flagged and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NUM_SRC | Request line of each source |
| bus_addr | input | ADDR_W | Byte address of register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_req | output | 1 | A candidate interrupt exists |
| irq_vec | output | 8 | Winning source number |
| irq_prio | output | 5 | Winning priority code |
| irq_vec_off | output | 32 | Offset register of the winning vector |

## Verification
The bench builds the controller with its default parameters: 64 sources, 8 external inputs starting at source 8, level sources 4 to 7, and a 12-bit address. With 64 sources there are two flag and enable words, so the bench can check that the word decode works and that the second word wins arbitration over the first. The external window, the level window and ordinary edge sources all lie in word 0, which lets one enable word cover all three behaviours. With sixteen priority words and sixty-four offset registers, a source in word 1 (number 40) exercises the upper priority lanes and offset decode.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned CTL_BASE    = 32'h000;
  localparam int unsigned STAT_BASE   = 32'h020;
  localparam int unsigned FLAG_BASE   = 32'h040;
  localparam int unsigned EN_BASE     = 32'h0C0;
  localparam int unsigned PRI_BASE    = 32'h140;
  localparam int unsigned OFF_BASE    = 32'h540;
  localparam int unsigned BANK_STRIDE = 16;
  localparam int unsigned PRIO_W      = 5;
  localparam int unsigned VEC_W       = 8;

  typedef enum logic [1:0] {
    AL_LOAD = 2'd0,
    AL_CLR  = 2'd1,
    AL_SET  = 2'd2,
    AL_NONE = 2'd3
  } alias_e;

  function automatic logic [31:0] upd32(input logic [31:0] cur,
                                        input logic [31:0] wd,
                                        input alias_e al);
    case (al)
      AL_LOAD: upd32 = wd;
      AL_CLR:  upd32 = cur & ~wd;
      AL_SET:  upd32 = cur | wd;
      default: upd32 = cur;
    endcase
  endfunction

  function automatic logic [PRIO_W-1:0] upd5(input logic [PRIO_W-1:0] cur,
                                             input logic [PRIO_W-1:0] wd,
                                             input alias_e al);
    case (al)
      AL_LOAD: upd5 = wd;
      AL_CLR:  upd5 = cur & ~wd;
      AL_SET:  upd5 = cur | wd;
      default: upd5 = cur;
    endcase
  endfunction
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell #(
  parameter bit LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic rise_pol,
  input  logic set_sw,
  input  logic clr_sw,
  output logic flag
);
  logic req_q;
  logic evt;
  logic flag_n;

  always_comb evt = rise_pol ? (req & ~req_q) : (~req & req_q);

  always_comb begin
    if (LEVEL) flag_n = (flag & ~(clr_sw & ~req)) | set_sw | req;
    else       flag_n = (flag & ~clr_sw) | set_sw | evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      req_q <= req;
      flag  <= flag_n;
    end
  end

  if (LEVEL) begin : g_lvl_chk
    // R5: a held level request keeps the flag set whatever software writes
    p_level_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> flag);
  end else begin : g_edge_chk
    // R4: an edge flag never drops without a software clear
    p_edge_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_sw) |=> flag);
  end
endmodule

// File: rtl/vic_pick.sv
module vic_pick
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          flag,
  input  logic [NUM_SRC-1:0]          en,
  input  logic [NUM_SRC*PRIO_W-1:0]   prio,
  output logic                        valid,
  output logic [VEC_W-1:0]            vec,
  output logic [PRIO_W-1:0]           code
);
  logic [PRIO_W-1:0] c;

  // Ascending scan with strict compare: equal codes keep the lower number
  always_comb begin
    valid = 1'b0;
    vec   = '0;
    code  = '0;
    c     = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      c = prio[i*PRIO_W +: PRIO_W];
      if (flag[i] && en[i] && (c[4:2] != 3'd0) && (!valid || (c > code))) begin
        valid = 1'b1;
        vec   = VEC_W'(i);
        code  = c;
      end
    end
  end

  // R10: a winner always carries a nonzero major level
  p_major_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (code[4:2] != 3'd0));
  // R8: with no winner the vector and code outputs are zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (vec == '0 && code == '0));
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_EXT = 8,
  parameter int ADDR_W  = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  input  logic                        bus_wr,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_SRC-1:0]          flag_q,
  input  logic                        win_valid,
  input  logic [VEC_W-1:0]            win_vec,
  input  logic [PRIO_W-1:0]           win_code,
  output logic [NUM_EXT-1:0]          pol_q,
  output logic [NUM_SRC-1:0]          en_q,
  output logic [NUM_SRC*PRIO_W-1:0]   prio_q,
  output logic [NUM_SRC-1:0]          set_sw,
  output logic [NUM_SRC-1:0]          clr_sw,
  output logic [31:0]                 win_off
);
  localparam int NW  = NUM_SRC / 32;
  localparam int NPW = NUM_SRC / 4;

  logic [31:0]  off_q [NUM_SRC];
  int unsigned  a;
  alias_e       al;
  logic         hit_ctl, hit_stat, hit_flag, hit_en, hit_pri, hit_off;
  int unsigned  fw, ew, pw, oi;

  // Address decode
  always_comb begin
    a        = 32'(bus_addr);
    al       = alias_e'(bus_addr[3:2]);
    hit_ctl  = (a < CTL_BASE + BANK_STRIDE);
    hit_stat = (a >= STAT_BASE) && (a < STAT_BASE + BANK_STRIDE);
    hit_flag = (a >= FLAG_BASE) && (a < FLAG_BASE + BANK_STRIDE * NW);
    hit_en   = (a >= EN_BASE)   && (a < EN_BASE + BANK_STRIDE * NW);
    hit_pri  = (a >= PRI_BASE)  && (a < PRI_BASE + BANK_STRIDE * NPW);
    hit_off  = (a >= OFF_BASE)  && (a < OFF_BASE + 4 * NUM_SRC);
    fw       = (a - FLAG_BASE) >> 4;
    ew       = (a - EN_BASE) >> 4;
    pw       = (a - PRI_BASE) >> 4;
    oi       = (a - OFF_BASE) >> 2;
  end

  // Flag strobes: the cells own the flags, this block only translates writes
  always_comb begin
    set_sw = '0;
    clr_sw = '0;
    if (bus_wr && hit_flag) begin
      for (int w = 0; w < NW; w++) begin
        if (fw == w) begin
          case (al)
            AL_LOAD: begin
              set_sw[w*32 +: 32] = bus_wdata;
              clr_sw[w*32 +: 32] = ~bus_wdata;
            end
            AL_CLR:  clr_sw[w*32 +: 32] = bus_wdata;
            AL_SET:  set_sw[w*32 +: 32] = bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  // Control, enable and priority banks with clear/set aliases
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q  <= '0;
      en_q   <= '0;
      prio_q <= '0;
    end else if (bus_wr && al != AL_NONE) begin
      if (hit_ctl) begin
        case (al)
          AL_LOAD: pol_q <= bus_wdata[NUM_EXT-1:0];
          AL_CLR:  pol_q <= pol_q & ~bus_wdata[NUM_EXT-1:0];
          default: pol_q <= pol_q | bus_wdata[NUM_EXT-1:0];
        endcase
      end
      for (int w = 0; w < NW; w++) begin
        if (hit_en && ew == w)
          en_q[w*32 +: 32] <= upd32(en_q[w*32 +: 32], bus_wdata, al);
      end
      for (int p = 0; p < NPW; p++) begin
        if (hit_pri && pw == p) begin
          for (int l = 0; l < 4; l++) begin
            prio_q[(p*4+l)*PRIO_W +: PRIO_W] <=
              upd5(prio_q[(p*4+l)*PRIO_W +: PRIO_W], bus_wdata[l*8 +: PRIO_W], al);
          end
        end
      end
    end
  end

  // Per-vector offsets: one plain word each, no aliases
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) off_q[i] <= '0;
    end else if (bus_wr && hit_off) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (oi == i) off_q[i] <= bus_wdata;
      end
    end
  end

  always_comb begin
    win_off = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (win_valid && win_vec == VEC_W'(i)) win_off = off_q[i];
    end
  end

  // Read path
  always_comb begin
    bus_rdata = '0;
    if (hit_ctl) begin
      bus_rdata[NUM_EXT-1:0] = pol_q;
    end else if (hit_stat) begin
      bus_rdata[12:0] = {win_code, win_vec};
    end else if (hit_flag) begin
      for (int w = 0; w < NW; w++) if (fw == w) bus_rdata = flag_q[w*32 +: 32];
    end else if (hit_en) begin
      for (int w = 0; w < NW; w++) if (ew == w) bus_rdata = en_q[w*32 +: 32];
    end else if (hit_pri) begin
      for (int p = 0; p < NPW; p++) begin
        if (pw == p) begin
          for (int l = 0; l < 4; l++)
            bus_rdata[l*8 +: PRIO_W] = prio_q[(p*4+l)*PRIO_W +: PRIO_W];
        end
      end
    end else if (hit_off) begin
      for (int i = 0; i < NUM_SRC; i++) if (oi == i) bus_rdata = off_q[i];
    end
  end

  // R2: a set-alias write to enable word 0 leaves every written bit set
  p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && a == EN_BASE + 8) |=> ((en_q[31:0] & $past(bus_wdata)) == $past(bus_wdata)));
  // R2: a clear-alias write to enable word 0 leaves every written bit clear
  p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && a == EN_BASE + 4) |=> ((en_q[31:0] & $past(bus_wdata)) == 32'd0));
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
#(
  parameter int                 NUM_SRC   = 64,
  parameter int                 NUM_EXT   = 8,
  parameter int                 EXT_BASE  = 8,
  parameter int                 ADDR_W    = 12,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = NUM_SRC'(32'h0000_00F0)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_wr,
  output logic [31:0]        bus_rdata,
  output logic               irq_req,
  output logic [7:0]         irq_vec,
  output logic [4:0]         irq_prio,
  output logic [31:0]        irq_vec_off
);
  logic [NUM_EXT-1:0]        pol_q;
  logic [NUM_SRC-1:0]        en_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]        set_sw;
  logic [NUM_SRC-1:0]        clr_sw;
  logic [NUM_SRC-1:0]        flag_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam bit IS_EXT = (i >= EXT_BASE) && (i < EXT_BASE + NUM_EXT);
    localparam bit IS_LVL = !IS_EXT && LEVEL_MAP[i];
    logic rise_sel;
    if (IS_EXT) begin : g_ext
      assign rise_sel = pol_q[i-EXT_BASE];
    end else begin : g_int
      assign rise_sel = 1'b1;
    end
    vic_src_cell #(.LEVEL(IS_LVL)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (src_req[i]),
      .rise_pol (rise_sel),
      .set_sw   (set_sw[i]),
      .clr_sw   (clr_sw[i]),
      .flag     (flag_q[i])
    );
  end

  vic_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .flag  (flag_q),
    .en    (en_q),
    .prio  (prio_q),
    .valid (irq_req),
    .vec   (irq_vec),
    .code  (irq_prio)
  );

  vic_regs #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .flag_q    (flag_q),
    .win_valid (irq_req),
    .win_vec   (irq_vec),
    .win_code  (irq_prio),
    .pol_q     (pol_q),
    .en_q      (en_q),
    .prio_q    (prio_q),
    .set_sw    (set_sw),
    .clr_sw    (clr_sw),
    .win_off   (irq_vec_off)
  );

  logic win_ok;
  always_comb begin
    win_ok = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (irq_vec == 8'(i)) win_ok = flag_q[i] & en_q[i];
  end

  // R7: the presented vector is flagged and enabled whenever irq_req is high
  p_win_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> win_ok);
  // R9: without a winner no offset is presented
  p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec_off == 32'd0));
endmodule

// File: tb/tb_vec_intc.sv
module tb_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_req = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic [4:0]  irq_prio;
  logic [31:0] irq_vec_off;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vec_intc dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_prio(irq_prio), .irq_vec_off(irq_vec_off)
  );

  // {wr, addr, data, expected read, tag}
  localparam int NT = 20;
  localparam logic [92:0] TBL [NT] = '{
    {1'b0, 12'h0C0, 32'h0,         32'h0000_0000, "R1"},
    {1'b1, 12'h0C0, 32'hF0F0_1234, 32'h0,         "R2"},
    {1'b0, 12'h0C0, 32'h0,         32'hF0F0_1234, "R2"},
    {1'b1, 12'h0C4, 32'h0000_0030, 32'h0,         "R2"},
    {1'b0, 12'h0C0, 32'h0,         32'hF0F0_1204, "R2"},
    {1'b1, 12'h0C8, 32'h0F00_0000, 32'h0,         "R2"},
    {1'b0, 12'h0C0, 32'h0,         32'hFFF0_1204, "R2"},
    {1'b1, 12'h0D0, 32'hA5A5_A5A5, 32'h0,         "R2"},
    {1'b0, 12'h0D0, 32'h0,         32'hA5A5_A5A5, "R2"},
    {1'b0, 12'h0C0, 32'h0,         32'hFFF0_1204, "R2"},
    {1'b1, 12'h140, 32'hFFFF_FFFF, 32'h0,         "R3"},
    {1'b0, 12'h140, 32'h0,         32'h1F1F_1F1F, "R3"},
    {1'b1, 12'h144, 32'h0000_0003, 32'h0,         "R3"},
    {1'b0, 12'h140, 32'h0,         32'h1F1F_1F1C, "R3"},
    {1'b1, 12'h000, 32'h0000_00FF, 32'h0,         "R6"},
    {1'b1, 12'h004, 32'h0000_000F, 32'h0,         "R6"},
    {1'b0, 12'h000, 32'h0,         32'h0000_00F0, "R6"},
    {1'b1, 12'h020, 32'hFFFF_FFFF, 32'h0,         "R8"},
    {1'b0, 12'h020, 32'h0,         32'h0000_0000, "R8"},
    {1'b1, 12'h554, 32'hDEAD_0005, 32'h0,         "R9"}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_req = '0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic chk_win(input string req, input logic r, input logic [7:0] v, input logic [4:0] p);
    chk(req, {23'd0, irq_req, irq_vec}, {23'd0, r, v});
    chk(req, {27'd0, irq_prio}, {27'd0, p});
  endtask

  initial begin
    logic [31:0] v;
    do_reset();

    // R1: reset state at the ports
    chk("R1", {22'd0, irq_req, irq_vec, irq_prio}, 32'd0);
    chk("R1", irq_vec_off, 32'd0);
    rd(12'h040, v); chk("R1", v, 32'd0);
    rd(12'h000, v); chk("R1", v, 32'd0);

    // Register table walk
    for (int k = 0; k < NT; k++) begin
      if (TBL[k][92]) wr(TBL[k][91:80], TBL[k][79:48]);
      else begin
        rd(TBL[k][91:80], v);
        chk(string'(TBL[k][15:0]), v, TBL[k][47:16]);
      end
    end
    rd(12'h554, v); chk("R9", v, 32'hDEAD_0005);

    // R4: edge source 2
    do_reset();
    wr(12'h0C0, 32'h4);
    wr(12'h140, 32'h0009_0000);
    @(negedge clk); src_req[2] = 1'b1;
    @(negedge clk);
    rd(12'h040, v); chk("R4", v, 32'h4);
    chk_win("R7", 1'b1, 8'd2, 5'h09);
    src_req[2] = 1'b0;
    repeat (3) @(negedge clk);
    rd(12'h040, v); chk("R4", v, 32'h4);
    wr(12'h044, 32'h4);
    rd(12'h040, v); chk("R4", v, 32'h0);
    src_req[2] = 1'b1;
    @(negedge clk);
    wr(12'h044, 32'h4);
    @(negedge clk);
    rd(12'h040, v); chk("R4", v, 32'h0);
    chk("R4", {31'd0, irq_req}, 32'd0);
    src_req[2] = 1'b0;

    // R5: level source 5
    do_reset();
    wr(12'h0C0, 32'h20);
    wr(12'h150, 32'h0000_0800);
    @(negedge clk); src_req[5] = 1'b1;
    @(negedge clk);
    chk_win("R5", 1'b1, 8'd5, 5'h08);
    wr(12'h044, 32'h20);
    rd(12'h040, v); chk("R5", v, 32'h20);
    wr(12'h040, 32'h0);
    rd(12'h040, v); chk("R5", v, 32'h20);
    src_req[5] = 1'b0;
    repeat (2) @(negedge clk);
    rd(12'h040, v); chk("R5", v, 32'h20);
    wr(12'h044, 32'h20);
    rd(12'h040, v); chk("R5", v, 32'h0);
    chk("R5", {31'd0, irq_req}, 32'd0);

    // R7/R8/R9: arbitration, status word and offsets
    do_reset();
    wr(12'h0C0, 32'hFFFF_FFFF);
    wr(12'h140, 32'h0D0C_0D00);
    wr(12'h048, 32'h0000_000E);
    chk_win("R7", 1'b1, 8'd1, 5'h0D);
    chk("R9", irq_vec_off, 32'd0);
    wr(12'h044, 32'h2);
    chk_win("R7", 1'b1, 8'd3, 5'h0D);
    wr(12'h044, 32'h8);
    chk_win("R7", 1'b1, 8'd2, 5'h0C);
    rd(12'h020, v); chk("R8", v, 32'h0000_0C02);
    wr(12'h0D0, 32'h100);
    wr(12'h1E0, 32'h0000_001F);
    wr(12'h5E0, 32'h0000_4000);
    wr(12'h058, 32'h100);
    chk_win("R7", 1'b1, 8'd40, 5'h1F);
    chk("R9", irq_vec_off, 32'h0000_4000);
    rd(12'h020, v); chk("R8", v, 32'h0000_1F28);
    wr(12'h0D4, 32'h100);
    chk_win("R7", 1'b1, 8'd2, 5'h0C);

    // R10: major level zero never interrupts
    do_reset();
    wr(12'h0C0, 32'h1);
    wr(12'h140, 32'h3);
    wr(12'h048, 32'h1);
    chk("R10", {31'd0, irq_req}, 32'd0);
    rd(12'h020, v); chk("R10", v, 32'd0);
    wr(12'h148, 32'h4);
    chk_win("R10", 1'b1, 8'd0, 5'h07);

    // R6: external source 8 with polarity select
    do_reset();
    wr(12'h0C0, 32'h100);
    wr(12'h160, 32'h8);
    @(negedge clk); src_req[8] = 1'b1;
    @(negedge clk);
    rd(12'h040, v); chk("R6", v, 32'h0);
    src_req[8] = 1'b0;
    @(negedge clk);
    rd(12'h040, v); chk("R6", v, 32'h100);
    chk_win("R6", 1'b1, 8'd8, 5'h08);
    wr(12'h044, 32'h100);
    wr(12'h008, 32'h1);
    rd(12'h000, v); chk("R6", v, 32'h1);
    src_req[8] = 1'b1;
    @(negedge clk);
    rd(12'h040, v); chk("R6", v, 32'h100);
    wr(12'h044, 32'h100);
    src_req[8] = 1'b0;
    @(negedge clk);
    rd(12'h040, v); chk("R6", v, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule